// File: doc/BRIEF.md
# Joinable Two-Channel Pulse-Width Modulator

This block produces two pulse-width modulated outputs from a single system clock. Each channel has its own period, duty, polarity, alignment and clock-source settings. A shared prescaler supplies either an undivided tick or a divided tick. When the join control is set, the two 8-bit channels work as one 16-bit channel. The even channel then supplies the upper byte of the period and duty, and the odd channel supplies the lower byte. The joined waveform leaves on the odd pin, under the odd channel's control bits.

Two status inputs, one for wait mode and one for freeze mode, can each cut off the prescaler's input clock. Each has its own stop-enable bit. When the clock is cut off, every counter holds where it was and continues from that point once the clock returns. All settings arrive as plain level inputs held by an outside register file. New period and duty values are taken up only when a period completes.

Top module: `pwm_pair_top`

## Requirements
- R1: After reset, with all control inputs at 0, both outputs sit at the inactive level, which is high when the polarity bit is 0.
- R2: In left-aligned mode (center bit 0), a channel counts ticks from 0 up to period-1 and then wraps. Its output is active while the count is below duty. The active level is high when the polarity bit is 1 and low when it is 0.
- R3: With the join bit at 0, each channel drives its own pin (bit 0 is even, bit 1 is odd) from its own settings, independent of the other channel.
- R4: With the join bit at 1, the 16-bit period is {even period, odd period} and the 16-bit duty is {even duty, odd duty}. The joined waveform appears on the odd pin.
- R5: With the join bit at 1, the odd channel's enable, polarity, center and clock-select bits govern the joined channel, and the even channel's copies have no effect. The even pin is held at the inactive level set by its own polarity bit.
- R6: In center-aligned mode (center bit 1), the count rises from 0 to period and falls back to 0, so one period lasts 2×period ticks. The output is active while the count is below duty.
- R7: A clock-select bit of 0 gives one tick on every ungated clock. A clock-select bit of 1 gives one tick every 4 ungated clocks, taken from the prescaler output.
- R8: With the wait-stop bit at 1 and the wait input high, the prescaler clock is cut off and all outputs hold. With the wait-stop bit at 0, counting continues in wait mode.
- R9: With the freeze-stop bit at 1 and the freeze input high, counting halts. Settings may still change during the halt. After the freeze input falls, counting resumes from the exact count at which it stopped.
- R10: A new period or duty value takes effect only when the current period ends, at the wrap to count 0.
- R11: Clearing a channel's enable bit forces its count to 0 and its output to the inactive level on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| waitMode | input | 1 | Chip is in wait mode |
| frzMode | input | 1 | Chip is in freeze (debug halt) mode |
| joinEn | input | 1 | Join both channels into one 16-bit channel |
| waitStopEn | input | 1 | Cut the prescaler clock while in wait mode |
| frzStopEn | input | 1 | Cut the prescaler clock while in freeze mode |
| chEn | input | 2 | Per-channel enable |
| chPol | input | 2 | Per-channel polarity (1 = active high) |
| chCenter | input | 2 | Per-channel center-aligned mode |
| chClkSel | input | 2 | Per-channel clock source (1 = divided tick) |
| chPeriod0 | input | 8 | Even channel period (upper byte when joined) |
| chPeriod1 | input | 8 | Odd channel period (lower byte when joined) |
| chDuty0 | input | 8 | Even channel duty (upper byte when joined) |
| chDuty1 | input | 8 | Odd channel duty (lower byte when joined) |
| pwmOut | output | 2 | PWM pins, bit 0 even, bit 1 odd |

## Verification
Each output comes straight from a registered count, so a change in count or shadow register shows on the pin in the cycle after the clock edge that produced it. Stop inputs and enable changes driven before an edge take effect at that edge. The bench drives inputs on falling edges and samples on the next falling edge, which puts every sample one register stage after its stimulus. Duty results are counted as active samples over a window that is a whole number of output periods, so the prescaler's phase does not matter. Checks that depend on exact timing, namely deferred loading and exact resumption, first wait for the one-sample active pulse of duty 1, which marks count 0. They then count samples from that point.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int NUM_CH = 2;

  // strobes from control to datapath, one bit per engine lane
  typedef struct packed {
    logic [NUM_CH-1:0] tick;
    logic [NUM_CH-1:0] run;
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_pair_engine.sv
module pwm_pair_engine #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic         tick,
  input  logic         center,
  input  logic         pol,
  input  logic [W-1:0] perIn,
  input  logic [W-1:0] dutyIn,
  output logic         pinOut
);
  logic [W-1:0] cnt, perSh, dutySh;
  logic         goingDown;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      perSh     <= '0;
      dutySh    <= '0;
      goingDown <= 1'b0;
    end else if (!run) begin
      cnt       <= '0;
      goingDown <= 1'b0;
      perSh     <= perIn;
      dutySh    <= dutyIn;
    end else if (tick) begin
      if (perSh == '0) begin
        cnt       <= '0;
        goingDown <= 1'b0;
        perSh     <= perIn;
        dutySh    <= dutyIn;
      end else if (!center) begin
        goingDown <= 1'b0;
        if (cnt >= perSh - 1'b1) begin
          cnt    <= '0;
          perSh  <= perIn;
          dutySh <= dutyIn;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (!goingDown) begin
        if (cnt >= perSh - 1'b1) begin
          cnt       <= perSh;
          goingDown <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt <= 1) begin
          cnt       <= '0;
          goingDown <= 1'b0;
          perSh     <= perIn;
          dutySh    <= dutyIn;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  logic isActive;
  assign isActive = run && (cnt < dutySh);
  assign pinOut   = isActive ? pol : ~pol;

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    (perSh != '0) |-> (cnt <= perSh));
  assert_load_at_wrap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(dutySh) || !$stable(perSh)) |-> (cnt == '0));
  assert_disable_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (cnt == '0));
  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (!rstN)
    (run && !tick) |=> $stable(cnt));
endmodule

// File: rtl/pwm_pair_ctrl.sv
module pwm_pair_ctrl
  import pwm_pair_pkg::*;
#(
  parameter int PRE_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              waitMode,
  input  logic              frzMode,
  input  logic              waitStopEn,
  input  logic              frzStopEn,
  input  logic              joinEn,
  input  logic [NUM_CH-1:0] chEn,
  input  logic [NUM_CH-1:0] chClkSel,
  output pwmStrobe_t        strobe
);
  localparam logic [PRE_LOG2-1:0] PRE_LAST = '1;

  logic                preOn;
  logic                slowTick;
  logic [PRE_LOG2-1:0] preCnt;

  assign preOn    = !(waitStopEn && waitMode) && !(frzStopEn && frzMode);
  assign slowTick = preOn && (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rstN)      preCnt <= '0;
    else if (preOn) preCnt <= preCnt + 1'b1;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gLane
    assign strobe.tick[g] = chClkSel[g] ? slowTick : preOn;
    // the even lane is parked while joined; the odd lane carries the joined channel
    if (g % 2 == 0) begin : gEven
      assign strobe.run[g] = chEn[g] && !joinEn;
    end else begin : gOdd
      assign strobe.run[g] = chEn[g];
    end
  end

  assert_wait_gates_R8: assert property (@(posedge clk) disable iff (!rstN)
    (waitStopEn && waitMode) |=> $stable(preCnt));
  assert_frz_gates_R9: assert property (@(posedge clk) disable iff (!rstN)
    (frzStopEn && frzMode) |=> $stable(preCnt));
  assert_no_tick_when_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((waitStopEn && waitMode) || (frzStopEn && frzMode)) |-> (strobe.tick == '0));
endmodule

// File: rtl/pwm_pair_dp.sv
module pwm_pair_dp
  import pwm_pair_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwmStrobe_t        strobe,
  input  logic              joinEn,
  input  logic [NUM_CH-1:0] chPol,
  input  logic [NUM_CH-1:0] chCenter,
  input  logic [CH_W-1:0]   chPeriod0,
  input  logic [CH_W-1:0]   chPeriod1,
  input  logic [CH_W-1:0]   chDuty0,
  input  logic [CH_W-1:0]   chDuty1,
  output logic [NUM_CH-1:0] pwmOut
);
  localparam int JW = 2 * CH_W;

  logic [JW-1:0] lanePer  [NUM_CH];
  logic [JW-1:0] laneDuty [NUM_CH];

  assign lanePer[0]  = {{CH_W{1'b0}}, chPeriod0};
  assign laneDuty[0] = {{CH_W{1'b0}}, chDuty0};
  assign lanePer[1]  = {joinEn ? chPeriod0 : {CH_W{1'b0}}, chPeriod1};
  assign laneDuty[1] = {joinEn ? chDuty0   : {CH_W{1'b0}}, chDuty1};

  for (genvar g = 0; g < NUM_CH; g++) begin : gEng
    localparam int LW = (g == NUM_CH - 1) ? JW : CH_W;
    pwm_pair_engine #(.W(LW)) uEng (
      .clk    (clk),
      .rstN   (rstN),
      .run    (strobe.run[g]),
      .tick   (strobe.tick[g]),
      .center (chCenter[g]),
      .pol    (chPol[g]),
      .perIn  (lanePer[g][LW-1:0]),
      .dutyIn (laneDuty[g][LW-1:0]),
      .pinOut (pwmOut[g])
    );
  end

  assert_even_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    joinEn |-> (pwmOut[0] == ~chPol[0]));
endmodule

// File: rtl/pwm_pair_top.sv
module pwm_pair_top
  import pwm_pair_pkg::*;
#(
  parameter int CH_W     = 8,
  parameter int PRE_LOG2 = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            waitMode,
  input  logic            frzMode,
  input  logic            joinEn,
  input  logic            waitStopEn,
  input  logic            frzStopEn,
  input  logic [1:0]      chEn,
  input  logic [1:0]      chPol,
  input  logic [1:0]      chCenter,
  input  logic [1:0]      chClkSel,
  input  logic [CH_W-1:0] chPeriod0,
  input  logic [CH_W-1:0] chPeriod1,
  input  logic [CH_W-1:0] chDuty0,
  input  logic [CH_W-1:0] chDuty1,
  output logic [1:0]      pwmOut
);
  pwmStrobe_t strobe;

  pwm_pair_ctrl #(.PRE_LOG2(PRE_LOG2)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .waitMode   (waitMode),
    .frzMode    (frzMode),
    .waitStopEn (waitStopEn),
    .frzStopEn  (frzStopEn),
    .joinEn     (joinEn),
    .chEn       (chEn),
    .chClkSel   (chClkSel),
    .strobe     (strobe)
  );

  pwm_pair_dp #(.CH_W(CH_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .joinEn    (joinEn),
    .chPol     (chPol),
    .chCenter  (chCenter),
    .chPeriod0 (chPeriod0),
    .chPeriod1 (chPeriod1),
    .chDuty0   (chDuty0),
    .chDuty1   (chDuty1),
    .pwmOut    (pwmOut)
  );
endmodule

// File: tb/sim_pwm_pair_top.sv
module sim_pwm_pair_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       waitMode = 1'b0, frzMode = 1'b0, joinEn = 1'b0;
  logic       waitStopEn = 1'b0, frzStopEn = 1'b0;
  logic [1:0] chEn = '0, chPol = '0, chCenter = '0, chClkSel = '0;
  logic [7:0] chPeriod0 = '0, chPeriod1 = '0, chDuty0 = '0, chDuty1 = '0;
  logic [1:0] pwmOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  pwm_pair_top u0 (
    .clk(clk), .rstN(rstN), .waitMode(waitMode), .frzMode(frzMode),
    .joinEn(joinEn), .waitStopEn(waitStopEn), .frzStopEn(frzStopEn),
    .chEn(chEn), .chPol(chPol), .chCenter(chCenter), .chClkSel(chClkSel),
    .chPeriod0(chPeriod0), .chPeriod1(chPeriod1),
    .chDuty0(chDuty0), .chDuty1(chDuty1), .pwmOut(pwmOut)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == WATCHDOG) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int actual, input int expected);
    checks = checks + 1;
    if (actual != expected) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic countLevel(input int lane, input logic lvl, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwmOut[lane] == lvl) c++;
    end
  endtask

  task automatic idleAll();
    @(negedge clk);
    chEn = '0; chPol = '0; chCenter = '0; chClkSel = '0; joinEn = 1'b0;
    waitMode = 1'b0; frzMode = 1'b0; waitStopEn = 1'b0; frzStopEn = 1'b0;
    @(negedge clk);
  endtask

  // wait for the one-sample active pulse of duty 1 (count 0)
  task automatic findZero(input int lane);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pwmOut[lane]) break;
    end
  endtask

  task automatic testReset();
    check("R1 reset outputs", pwmOut, 2'b11);
  endtask

  task automatic testLeftIndependent();
    int c0, c1;
    idleAll();
    chPol = 2'b01; chPeriod0 = 10; chDuty0 = 3; chPeriod1 = 8; chDuty1 = 6;
    @(negedge clk);
    chEn = 2'b11;
    repeat (30) @(negedge clk);
    fork
      countLevel(0, 1'b1, 40, c0);
      countLevel(1, 1'b0, 40, c1);
    join
    check("R2 left active-high duty 3/10", c0, 12);
    check("R3 odd channel own active-low duty 6/8", c1, 30);
  endtask

  task automatic testDisable();
    @(negedge clk);
    chPol = 2'b01; chEn = 2'b00;
    @(negedge clk);
    check("R11 even pin inactive low", pwmOut[0], 0);
    check("R11 odd pin inactive high", pwmOut[1], 1);
  endtask

  task automatic testCenter();
    int c;
    idleAll();
    chPol = 2'b01; chCenter = 2'b01; chPeriod0 = 10; chDuty0 = 3;
    @(negedge clk);
    chEn = 2'b01;
    repeat (25) @(negedge clk);
    countLevel(0, 1'b1, 100, c);
    check("R6 center period 20 active 5", c, 25);
  endtask

  task automatic testSlowClock();
    int c;
    idleAll();
    chPol = 2'b01; chClkSel = 2'b01; chPeriod0 = 5; chDuty0 = 2;
    @(negedge clk);
    chEn = 2'b01;
    repeat (40) @(negedge clk);
    countLevel(0, 1'b1, 100, c);
    check("R7 divided tick duty 2/5", c, 40);
  endtask

  task automatic testJoin();
    int c, cEven;
    idleAll();
    joinEn = 1'b1;
    chPol = 2'b10; chCenter = 2'b01; chClkSel = 2'b01;
    chPeriod0 = 8'h01; chPeriod1 = 8'h00; chDuty0 = 8'h00; chDuty1 = 8'h40;
    @(negedge clk);
    chEn = 2'b10;
    repeat (300) @(negedge clk);
    fork
      countLevel(1, 1'b1, 512, c);
      countLevel(0, 1'b0, 512, cEven);
    join
    check("R4 joined 16-bit duty 64/256 on odd pin", c, 128);
    check("R5 even pin held inactive while joined", cEven, 0);
    @(negedge clk);
    chEn = 2'b11; chPol = 2'b00;
    repeat (300) @(negedge clk);
    countLevel(1, 1'b1, 512, c);
    check("R5 odd polarity 0 governs joined pin", c, 384);
  endtask

  task automatic testWait();
    int c;
    logic held;
    idleAll();
    chPol = 2'b01; chPeriod0 = 10; chDuty0 = 3;
    @(negedge clk);
    chEn = 2'b01; waitMode = 1'b1;
    repeat (20) @(negedge clk);
    countLevel(0, 1'b1, 100, c);
    check("R8 wait without stop keeps counting", c, 30);
    findZero(0);
    waitStopEn = 1'b1;
    held = pwmOut[0];
    countLevel(0, held, 50, c);
    check("R8 wait stop holds output", c, 50);
    waitMode = 1'b0;
    repeat (20) @(negedge clk);
    countLevel(0, 1'b1, 100, c);
    check("R8 counting after wait exit", c, 30);
  endtask

  task automatic testFreeze();
    int c, k;
    idleAll();
    chPol = 2'b01; chPeriod0 = 10; chDuty0 = 1;
    @(negedge clk);
    chEn = 2'b01;
    repeat (15) @(negedge clk);
    findZero(0);
    frzStopEn = 1'b1; frzMode = 1'b1;
    countLevel(0, 1'b1, 20, c);
    check("R9 frozen at count 0 stays active", c, 20);
    frzMode = 1'b0;
    k = 0;
    for (int i = 1; i <= 30; i++) begin
      @(negedge clk);
      if (pwmOut[0]) begin k = i; break; end
    end
    check("R9 resumes from held count", k, 10);
    // settings written while frozen take effect after resume
    frzMode = 1'b1;
    chDuty0 = 4;
    repeat (10) @(negedge clk);
    frzStopEn = 1'b0;
    repeat (20) @(negedge clk);
    countLevel(0, 1'b1, 100, c);
    check("R9 duty written during freeze applies", c, 40);
  endtask

  task automatic testShadow();
    int c;
    idleAll();
    chPol = 2'b01; chPeriod0 = 10; chDuty0 = 1;
    @(negedge clk);
    chEn = 2'b01;
    repeat (15) @(negedge clk);
    findZero(0);
    chDuty0 = 9;
    countLevel(0, 1'b1, 9, c);
    check("R10 new duty deferred to period end", c, 0);
    @(negedge clk);
    check("R10 new duty active after wrap", pwmOut[0], 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLeftIndependent();
    testDisable();
    testCenter();
    testSlowClock();
    testJoin();
    testWait();
    testFreeze();
    testShadow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule